// File: doc/BRIEF.md
# Loop Activation Sequencer

This block is the control state machine that brings a two-wire digital subscriber loop transceiver from silence to a linked, payload-carrying state. It runs in one of two roles, selected per activation: the network-side role, which starts with a short wake-up burst and then waits for the far end to go quiet, and the customer-side role, which announces itself and must hear a reply inside a bounded window. The analogue work is done elsewhere: echo cancellation, timing recovery and line coding report to this block only through three strobes (far-end signal seen, far-end signal lost, full-duplex training done).

The sequencer tells the line driver which named signal to send, keeps a four-bit status nibble (activation in progress, superframe sync, error, link up), and drives an enable for the 2B+D payload that is kept apart from link-up: the link can be up while the payload stays blocked until the customer enable, or in verified mode a received M4 act bit, releases it. All timing is counted on a 1 ms tick input, and every duration is a parameter so a bench can shrink the 15 s watchdog and 480 ms reply window.

Top module: `lact_seq`

## Requirements
- R1: A synchronous active-high `rst` puts `tx_sel` at 0 (quiet), `status` at 4'b0000, `payload_en` at 0 and `req_clr` at 0.
- R2: With `status` not in activation or link, `act_req` high at a clock edge starts activation: from that edge `status` is 4'b0001 (bit 0 = in progress) and `req_clr` is high for exactly one cycle; `mode_lt` = 1 picks the network-side role, 0 the customer-side role.
- R3: In the network-side role `tx_sel` is 1 (wake-up burst) from the start edge until the edge after the TL_MS-th counted tick, then 0 (quiet).
- R4: In the network-side role, while quiet after the burst, `fe_present` has no effect and an `fe_lost` strobe makes `tx_sel` 3 at the next edge; after SL1_MS ticks it becomes 4, and in code 4 an `fd_done` that arrives before `fe_present` has no effect.
- R5: In the customer-side role `tx_sel` is 2 (tone) for TN_MS ticks, then 3; while 3, an `fe_present` strobe makes it 4 at the next edge.
- R6: In code 4 after the far end has been seen, `fd_done` makes `status` 4'b1011 and `tx_sel` 5 (final signal) at the next edge.
- R7: `payload_en` is 0 whenever `status` is not 4'b1011; while linked it follows `cust_en` in the same cycle when no M4 act bit has been taken.
- R8: While linked, an `m4_act` strobe is remembered from the next edge on; from then `payload_en` = `cust_en` OR `verif_mode`.
- R9: In customer-side code 3, REPLY_MS ticks with no `fe_present` end activation at the edge after the last tick: `tx_sel` 0, `status` 4'b0100 (bit 2 = error).
- R10: WDOG_MS ticks after the start edge without reaching link-up end activation at the next edge with `tx_sel` 0 and `status` 4'b0100, ahead of any other transition.
- R11: After an abort the error bit stays set until the next start, which clears it (`status` 4'b0001).
- R12: Once linked, `act_req`, the line strobes and any number of ticks leave `status` at 4'b1011 and `tx_sel` at 5 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| mode_lt | input | 1 | 1 = network-side role, 0 = customer-side role, sampled at start |
| act_req | input | 1 | Activation request |
| cust_en | input | 1 | Customer enable for the payload |
| verif_mode | input | 1 | Verified activation mode: M4 act bit also releases payload |
| m4_act | input | 1 | Strobe: M4 act bit received |
| fe_present | input | 1 | Strobe: far-end signal detected |
| fe_lost | input | 1 | Strobe: far-end signal lost |
| fd_done | input | 1 | Strobe: full-duplex training done |
| tx_sel | output | 3 | Signal to send: 0 quiet, 1 TL, 2 TN, 3 SN1/SL1, 4 SN2/SL2, 5 SN3/SL3 |
| payload_en | output | 1 | 2B+D payload enable |
| status | output | 4 | {link up, error, superframe sync, in progress} |
| req_clr | output | 1 | One-cycle pulse clearing the request bit |

## Verification
Every strobe and `act_req` acts on the first clock edge that sees it, so `tx_sel`, `status` and `req_clr` are checked one edge later, while `payload_en` follows `cust_en` combinationally and is checked in the same cycle, and an `m4_act` strobe shows one edge later. Timer-driven moves (burst end, SL1 end, reply window, watchdog) happen one edge after the edge that counted the final tick, so the bench counts ticks itself, checks the old code right after the last tick and the new one after a further edge. Inputs change just after a falling edge and outputs are read at the next falling edge, with ticks spaced by random gaps so the checks do not depend on a fixed cadence.

// File: rtl/lact_pkg.sv
package lact_pkg;

   typedef enum logic [2:0] {
      TX_QUIET = 3'd0,
      TX_TL    = 3'd1,
      TX_TN    = 3'd2,
      TX_S1    = 3'd3,
      TX_S2    = 3'd4,
      TX_S3    = 3'd5
   } tx_sig_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_LT_TL,
      ST_LT_WAIT,
      ST_LT_SL1,
      ST_LT_SL2,
      ST_LT_SYNC,
      ST_NT_TN,
      ST_NT_SN1,
      ST_NT_SN2,
      ST_LINKED
   } seq_state_e;

   localparam int unsigned STAT_PROG = 0;
   localparam int unsigned STAT_SYNC = 1;
   localparam int unsigned STAT_ERR  = 2;
   localparam int unsigned STAT_LINK = 3;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/lact_ms_timer.sv
module lact_ms_timer #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic         tick,
   input  logic [W-1:0] limit,
   output logic         expired
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || clr)
         cnt_q <= '0;
      else if (tick && (cnt_q != limit))
         cnt_q <= cnt_q + 1'b1;
   end

   assign expired = (cnt_q == limit);

   // once the limit is reached the count holds until cleared
   assert_timer_holds_R10: assert property (@(posedge clk) disable iff (rst)
      (expired && !clr && $stable(limit)) |=> expired);

endmodule

// File: rtl/lact_fsm.sv
module lact_fsm
   import lact_pkg::*;
#(
   parameter int unsigned PH_W   = 3,
   parameter int unsigned TL_MS  = 3,
   parameter int unsigned TN_MS  = 6,
   parameter int unsigned SL1_MS = 24
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            mode_lt_i,
   input  logic            act_req_i,
   input  logic            fe_present_i,
   input  logic            fe_lost_i,
   input  logic            fd_done_i,
   input  logic            ph_exp_i,
   input  logic            reply_exp_i,
   input  logic            wd_exp_i,
   output seq_state_e      state_o,
   output logic            ph_clr_o,
   output logic [PH_W-1:0] ph_limit_o,
   output logic            in_act_o,
   output logic            err_o,
   output logic            req_clr_o
);

   localparam logic [PH_W-1:0] LIM_TL  = PH_W'(TL_MS);
   localparam logic [PH_W-1:0] LIM_TN  = PH_W'(TN_MS);
   localparam logic [PH_W-1:0] LIM_SL1 = PH_W'(SL1_MS);

   seq_state_e state_q, state_d;
   logic       err_q, req_clr_q;
   logic       start, abort, in_act;

   assign in_act = (state_q != ST_IDLE) && (state_q != ST_LINKED);
   assign start  = (state_q == ST_IDLE) && act_req_i;

   always_comb begin
      state_d = state_q;
      abort   = 1'b0;
      unique case (state_q)
         ST_IDLE:    if (act_req_i) state_d = mode_lt_i ? ST_LT_TL : ST_NT_TN;
         ST_LT_TL:   if (ph_exp_i) state_d = ST_LT_WAIT;
         ST_LT_WAIT: if (fe_lost_i) state_d = ST_LT_SL1;
         ST_LT_SL1:  if (ph_exp_i) state_d = ST_LT_SL2;
         ST_LT_SL2:  if (fe_present_i) state_d = ST_LT_SYNC;
         ST_LT_SYNC: if (fd_done_i) state_d = ST_LINKED;
         ST_NT_TN:   if (ph_exp_i) state_d = ST_NT_SN1;
         ST_NT_SN1: begin
            if (fe_present_i) begin
               state_d = ST_NT_SN2;
            end else if (reply_exp_i) begin
               state_d = ST_IDLE;
               abort   = 1'b1;
            end
         end
         ST_NT_SN2:  if (fd_done_i) state_d = ST_LINKED;
         ST_LINKED:  state_d = ST_LINKED;
         default:    state_d = ST_IDLE;
      endcase
      // the activation watchdog overrides every other move
      if (in_act && wd_exp_i) begin
         state_d = ST_IDLE;
         abort   = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= ST_IDLE;
         err_q     <= 1'b0;
         req_clr_q <= 1'b0;
      end else begin
         state_q   <= state_d;
         req_clr_q <= start;
         if (start)
            err_q <= 1'b0;
         else if (abort)
            err_q <= 1'b1;
      end
   end

   always_comb begin
      unique case (state_q)
         ST_LT_TL:  ph_limit_o = LIM_TL;
         ST_NT_TN:  ph_limit_o = LIM_TN;
         ST_LT_SL1: ph_limit_o = LIM_SL1;
         default:   ph_limit_o = LIM_SL1;
      endcase
   end

   assign ph_clr_o  = (state_d != state_q);
   assign state_o   = state_q;
   assign in_act_o  = in_act;
   assign err_o     = err_q;
   assign req_clr_o = req_clr_q;

   assert_start_R2: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_IDLE && act_req_i) |=>
         (req_clr_q && !err_q && (state_q == ST_LT_TL || state_q == ST_NT_TN)));

   assert_reply_abort_R9: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_NT_SN1 && reply_exp_i && !fe_present_i) |=>
         (state_q == ST_IDLE && err_q));

   assert_wdog_abort_R10: assert property (@(posedge clk) disable iff (rst)
      (in_act && wd_exp_i) |=> (state_q == ST_IDLE && err_q));

   assert_link_holds_R12: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_LINKED) |=> (state_q == ST_LINKED));

   assert_req_pulse_R2: assert property (@(posedge clk) disable iff (rst)
      req_clr_q |=> !req_clr_q);

endmodule

// File: rtl/lact_payload_gate.sv
module lact_payload_gate #(
   parameter bit REGISTERED = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic linked_i,
   input  logic cust_en_i,
   input  logic verif_mode_i,
   input  logic m4_act_i,
   output logic payload_en_o
);

   logic m4_seen_q;
   logic open_now;

   always_ff @(posedge clk) begin
      if (rst || !linked_i)
         m4_seen_q <= 1'b0;
      else if (m4_act_i)
         m4_seen_q <= 1'b1;
   end

   assign open_now = linked_i && (cust_en_i || (verif_mode_i && m4_seen_q));

   if (REGISTERED) begin : g_reg
      logic pay_q;
      always_ff @(posedge clk) begin
         if (rst) pay_q <= 1'b0;
         else     pay_q <= open_now;
      end
      assign payload_en_o = pay_q;
   end else begin : g_comb
      assign payload_en_o = open_now;
   end

   assert_payload_linked_R7: assert property (@(posedge clk) disable iff (rst)
      payload_en_o |-> linked_i);

   assert_m4_memory_R8: assert property (@(posedge clk) disable iff (rst)
      (linked_i && m4_act_i) |=> (m4_seen_q || !linked_i));

endmodule

// File: rtl/lact_seq.sv
module lact_seq
   import lact_pkg::*;
#(
   parameter int unsigned WDOG_MS     = 15000,
   parameter int unsigned REPLY_MS    = 480,
   parameter int unsigned TL_MS       = 3,
   parameter int unsigned TN_MS       = 6,
   parameter int unsigned SL1_MS      = 24,
   parameter bit          PAYLOAD_REG = 1'b0
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       ms_tick,
   input  logic       mode_lt,
   input  logic       act_req,
   input  logic       cust_en,
   input  logic       verif_mode,
   input  logic       m4_act,
   input  logic       fe_present,
   input  logic       fe_lost,
   input  logic       fd_done,
   output logic [2:0] tx_sel,
   output logic       payload_en,
   output logic [3:0] status,
   output logic       req_clr
);

   localparam int unsigned PH_MAX = max3(TL_MS, TN_MS, SL1_MS);
   localparam int unsigned PH_W   = $clog2(PH_MAX + 1);
   localparam int unsigned WD_W   = $clog2(WDOG_MS + 1);
   localparam int unsigned RP_W   = $clog2(REPLY_MS + 1);

   if (TL_MS < 1 || TN_MS < 1 || SL1_MS < 1 || REPLY_MS < 1) begin : g_bad_len
      $error("lact_seq: every phase length must be at least one tick");
   end
   if (WDOG_MS <= REPLY_MS + TN_MS) begin : g_bad_wdog
      $error("lact_seq: watchdog must outlast the customer-side reply window");
   end

   seq_state_e      state;
   logic            ph_clr, ph_exp, reply_exp, wd_exp;
   logic [PH_W-1:0] ph_limit;
   logic            in_act, err, linked;

   lact_fsm #(
      .PH_W  (PH_W),
      .TL_MS (TL_MS),
      .TN_MS (TN_MS),
      .SL1_MS(SL1_MS)
   ) fsm_i (
      .clk         (clk),
      .rst         (rst),
      .mode_lt_i   (mode_lt),
      .act_req_i   (act_req),
      .fe_present_i(fe_present),
      .fe_lost_i   (fe_lost),
      .fd_done_i   (fd_done),
      .ph_exp_i    (ph_exp),
      .reply_exp_i (reply_exp),
      .wd_exp_i    (wd_exp),
      .state_o     (state),
      .ph_clr_o    (ph_clr),
      .ph_limit_o  (ph_limit),
      .in_act_o    (in_act),
      .err_o       (err),
      .req_clr_o   (req_clr)
   );

   lact_ms_timer #(.W(PH_W)) phase_tmr_i (
      .clk    (clk),
      .rst    (rst),
      .clr    (ph_clr),
      .tick   (ms_tick),
      .limit  (ph_limit),
      .expired(ph_exp)
   );

   lact_ms_timer #(.W(RP_W)) reply_tmr_i (
      .clk    (clk),
      .rst    (rst),
      .clr    (state != ST_NT_SN1),
      .tick   (ms_tick),
      .limit  (RP_W'(REPLY_MS)),
      .expired(reply_exp)
   );

   lact_ms_timer #(.W(WD_W)) wdog_tmr_i (
      .clk    (clk),
      .rst    (rst),
      .clr    (!in_act),
      .tick   (ms_tick),
      .limit  (WD_W'(WDOG_MS)),
      .expired(wd_exp)
   );

   assign linked = (state == ST_LINKED);

   lact_payload_gate #(.REGISTERED(PAYLOAD_REG)) gate_i (
      .clk         (clk),
      .rst         (rst),
      .linked_i    (linked),
      .cust_en_i   (cust_en),
      .verif_mode_i(verif_mode),
      .m4_act_i    (m4_act),
      .payload_en_o(payload_en)
   );

   always_comb begin
      unique case (state)
         ST_LT_TL:                          tx_sel = TX_TL;
         ST_NT_TN:                          tx_sel = TX_TN;
         ST_LT_SL1, ST_NT_SN1:              tx_sel = TX_S1;
         ST_LT_SL2, ST_LT_SYNC, ST_NT_SN2:  tx_sel = TX_S2;
         ST_LINKED:                         tx_sel = TX_S3;
         default:                           tx_sel = TX_QUIET;
      endcase
   end

   always_comb begin
      status = '0;
      if (linked) begin
         status[STAT_LINK] = 1'b1;
         status[STAT_SYNC] = 1'b1;
         status[STAT_PROG] = 1'b1;
      end else if (in_act) begin
         status[STAT_PROG] = 1'b1;
      end else begin
         status[STAT_ERR]  = err;
      end
   end

   assert_link_needs_train_R6: assert property (@(posedge clk) disable iff (rst)
      $rose(status[STAT_LINK]) |-> $past(fd_done));

   assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (rst)
      (status[STAT_PROG] == 1'b0) |-> (tx_sel == 3'd0 && !payload_en));

   assert_err_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
      status[STAT_ERR] |-> (status[STAT_PROG] == 1'b0 && status[STAT_LINK] == 1'b0));

endmodule

// File: tb/lact_seq_tb_top.sv
module lact_seq_tb_top;

   localparam int unsigned WDOG  = 120;
   localparam int unsigned REPLY = 10;
   localparam int unsigned TLN   = 3;
   localparam int unsigned TNN   = 4;
   localparam int unsigned SL1N  = 5;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       ms_tick = 1'b0, mode_lt = 1'b0, act_req = 1'b0, cust_en = 1'b0;
   logic       verif_mode = 1'b0, m4_act = 1'b0, fe_present = 1'b0;
   logic       fe_lost = 1'b0, fd_done = 1'b0;
   logic [2:0] tx_sel;
   logic       payload_en;
   logic [3:0] status;
   logic       req_clr;

   int unsigned n_chk  = 0;
   int unsigned n_fail = 0;
   bit          m4_seen_m;

   always #10 clk = ~clk;

   lact_seq #(
      .WDOG_MS (WDOG),
      .REPLY_MS(REPLY),
      .TL_MS   (TLN),
      .TN_MS   (TNN),
      .SL1_MS  (SL1N)
   ) dut_i (
      .clk(clk), .rst(rst), .ms_tick(ms_tick), .mode_lt(mode_lt), .act_req(act_req),
      .cust_en(cust_en), .verif_mode(verif_mode), .m4_act(m4_act),
      .fe_present(fe_present), .fe_lost(fe_lost), .fd_done(fd_done),
      .tx_sel(tx_sel), .payload_en(payload_en), .status(status), .req_clr(req_clr)
   );

   function automatic bit exp_payload(bit linked, bit ce, bit vm, bit seen);
      return linked && (ce || (vm && seen));
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic chk_tx(input string tag, input int exp);
      chk(tx_sel == exp[2:0], tag, tx_sel, exp);
   endtask

   task automatic chk_st(input string tag, input int exp);
      chk(status == exp[3:0], tag, status, exp);
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic tick();
      ms_tick = 1'b1; cyc(); ms_tick = 1'b0;
   endtask

   task automatic tick_n(input int unsigned n);
      for (int unsigned i = 0; i < n; i++) begin
         repeat ($urandom_range(1, 3)) cyc();
         tick();
      end
   endtask

   task automatic pulse(ref logic s);
      s = 1'b1; cyc(); s = 1'b0;
   endtask

   task automatic do_reset();
      act_req = 0; cust_en = 0; verif_mode = 0; m4_act = 0;
      fe_present = 0; fe_lost = 0; fd_done = 0; ms_tick = 0;
      rst = 1'b1; cyc(); cyc(); rst = 1'b0;
   endtask

   task automatic start(input bit lt);
      mode_lt = lt; act_req = 1'b1; cyc(); act_req = 1'b0;
   endtask

   // customer-side path up to link, with a random reply delay
   task automatic nt_to_link(input int unsigned wait_ticks);
      start(1'b0);
      chk_tx("R5 tone after start", 2);
      tick_n(TNN);
      chk_tx("R5 tone held to last tick", 2);
      cyc();
      chk_tx("R5 SN1 after tone", 3);
      tick_n(wait_ticks);
      pulse(fe_present);
      chk_tx("R5 SN2 on far-end signal", 4);
      chk_st("R5 still in progress", 4'b0001);
      pulse(fd_done);
      chk_tx("R6 SN3 on training done", 5);
      chk_st("R6 linked status", 4'b1011);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      void'($urandom(32'h1ac7));
      cyc(); cyc();
      // R1: reset state
      chk_tx("R1 reset tx", 0);
      chk_st("R1 reset status", 0);
      chk(payload_en == 1'b0, "R1 reset payload", payload_en, 0);
      chk(req_clr == 1'b0, "R1 reset req_clr", req_clr, 0);
      rst = 1'b0;
      cyc();

      // network-side full path
      start(1'b1);
      chk(req_clr == 1'b1, "R2 req_clr pulse", req_clr, 1);
      chk_st("R2 in progress", 4'b0001);
      chk_tx("R3 burst at start", 1);
      cyc();
      chk(req_clr == 1'b0, "R2 req_clr single cycle", req_clr, 0);
      tick_n(TLN - 1);
      chk_tx("R3 burst before last tick", 1);
      tick_n(1);
      chk_tx("R3 burst through last tick", 1);
      cyc();
      chk_tx("R3 quiet after burst", 0);
      pulse(fe_present);
      chk_tx("R4 fe_present ignored while waiting", 0);
      pulse(fe_lost);
      chk_tx("R4 SL1 on loss", 3);
      tick_n(SL1N);
      chk_tx("R4 SL1 held to last tick", 3);
      cyc();
      chk_tx("R4 SL2 after SL1", 4);
      pulse(fd_done);
      chk_tx("R4 early training done ignored", 4);
      chk_st("R4 early training status", 4'b0001);
      pulse(fe_present);
      chk_tx("R4 SL2 while training", 4);
      pulse(fd_done);
      chk_tx("R6 SL3 on training done", 5);
      chk_st("R6 linked status", 4'b1011);
      chk(payload_en == 1'b0, "R7 payload blocked without enable", payload_en, 0);

      // payload directed
      cust_en = 1'b1; #1;
      chk(payload_en == 1'b1, "R7 payload follows cust_en", payload_en, 1);
      cust_en = 1'b0; #1;
      chk(payload_en == 1'b0, "R7 payload drops with cust_en", payload_en, 0);
      verif_mode = 1'b1; cyc();
      chk(payload_en == 1'b0, "R8 verified without M4", payload_en, 0);
      pulse(m4_act);
      m4_seen_m = 1'b1;
      chk(payload_en == 1'b1, "R8 M4 act opens payload", payload_en, 1);
      verif_mode = 1'b0; #1;
      chk(payload_en == 1'b0, "R8 M4 needs verified mode", payload_en, 0);

      // R12: linked state ignores everything else
      act_req = 1'b1; fe_lost = 1'b1; cyc(); act_req = 1'b0; fe_lost = 1'b0;
      tick_n(WDOG + 5);
      chk_st("R12 link held", 4'b1011);
      chk_tx("R12 final signal held", 5);
      chk(req_clr == 1'b0, "R12 no request clear", req_clr, 0);

      // random payload gating after a fresh link
      do_reset();
      nt_to_link($urandom_range(0, REPLY - 1));
      m4_seen_m = 1'b0;
      for (int i = 0; i < 40; i++) begin
         bit pm;
         cust_en    = 1'($urandom_range(0, 1));
         verif_mode = 1'($urandom_range(0, 1));
         pm         = ($urandom_range(0, 7) == 0);
         m4_act     = pm;
         cyc();
         if (pm) m4_seen_m = 1'b1;
         chk(payload_en == exp_payload(1'b1, cust_en, verif_mode, m4_seen_m),
             "R8 random payload", payload_en,
             exp_payload(1'b1, cust_en, verif_mode, m4_seen_m));
         m4_act = 1'b0;
      end
      cust_en = 0; verif_mode = 0;

      // customer-side random reply delays
      for (int k = 0; k < 4; k++) begin
         do_reset();
         nt_to_link($urandom_range(0, REPLY - 1));
         chk(payload_en == 1'b0, "R7 payload off after link", payload_en, 0);
      end

      // R9: reply window expiry
      do_reset();
      start(1'b0);
      tick_n(TNN);
      cyc();
      chk_tx("R9 SN1 sent", 3);
      tick_n(REPLY);
      chk_st("R9 still in progress at last tick", 4'b0001);
      cyc();
      chk_tx("R9 quiet after reply window", 0);
      chk_st("R9 error status", 4'b0100);
      cyc(); cyc();
      chk_st("R11 error held", 4'b0100);
      start(1'b1);
      chk_st("R11 error cleared by start", 4'b0001);

      // R10: activation watchdog
      do_reset();
      start(1'b1);
      tick_n(WDOG - 1);
      chk_st("R10 in progress before limit", 4'b0001);
      tick_n(1);
      chk_st("R10 in progress at limit tick", 4'b0001);
      cyc();
      chk_st("R10 abort status", 4'b0100);
      chk_tx("R10 quiet after abort", 0);

      // R10: watchdog wins over training done in the same cycle
      do_reset();
      start(1'b1);
      tick_n(TLN); cyc();
      pulse(fe_lost);
      tick_n(SL1N); cyc();
      pulse(fe_present);
      tick_n(WDOG - TLN - SL1N);
      fd_done = 1'b1; cyc(); fd_done = 1'b0;
      chk_st("R10 watchdog beats training done", 4'b0100);

      // R1: reset mid-activation
      start(1'b0);
      tick_n(1);
      rst = 1'b1; cyc(); rst = 1'b0;
      chk_st("R1 reset mid-activation status", 0);
      chk_tx("R1 reset mid-activation tx", 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule